// File: doc/BRIEF.md
# Per-CPU Interrupt Mask and Router

This block steers 32 level-sensitive interrupt inputs to two processors. Each processor owns a private bank of state: an enable word with one bit per interrupt, and a set of four-bit routing codes, one per interrupt. A routing code of zero leaves an interrupt unconnected for that processor. A code from 1 to 15 sends it to one of fifteen output lines of that processor. Because the two banks are separate, software can deliver an interrupt to one processor, to both, or to neither.

Every cycle the block ANDs the raw inputs with each bank's enable word and decodes each bank's routing codes. Each output line of a processor is the OR of all inputs that reach it. The line vectors are registered. A simple single-cycle register bus with combinational read data reads and writes both banks. The bus also reads a status word that shows the raw input levels.

Top module: `irq_steer`

## Requirements
- R1: After reset every enable bit and every routing code in both banks is 0. All output lines are 0, and every bank register reads back 0.
- R2: The enable word of processor c is at address c*0x100 + 0x00. Bit n enables interrupt n. A write to it is stored at the next clock edge and reads back unchanged.
- R3: The routing code of interrupt n for processor c is at address c*0x100 + 0x04 + 4*(3 - n/8), in bits 4*(n mod 8) + 3 down to 4*(n mod 8). So interrupt 31 is in bits 31:28 at offset 0x04, interrupt 24 in bits 3:0 at 0x04, interrupt 7 in bits 31:28 at 0x10, and interrupt 0 in bits 3:0 at 0x10.
- R4: An interrupt whose routing code is 0 for a processor drives none of that processor's lines, even when it is enabled and asserted.
- R5: An interrupt that is asserted, enabled and has code k (1 to 15) for a processor drives that processor's output line k-1. Line j of processor c is output bit c*15 + j.
- R6: An interrupt whose enable bit is 0 for a processor drives none of that processor's lines, whatever its routing code.
- R7: The two banks are independent. Writing one bank changes neither the other bank's registers nor the other processor's lines.
- R8: An output line is the OR of every asserted, enabled input routed to it, so it stays high while any one of them remains.
- R9: The output lines are registered. They reflect the inputs and register contents present at the previous rising clock edge.
- R10: Address 0x020 reads the raw level of all 32 inputs, bit n for input n. Writes to it change no state.
- R11: Reads of unmapped addresses (for example 0x120 and 0x200) return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | Level-sensitive interrupt inputs |
| busSel | input | 1 | Register access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| cpuLines | output | 30 | Output lines, processor c line j at bit c*15 + j |

## Verification
The hardest state to reach is one where several inputs with mixed enable bits and codes share a line across both banks at once. A single-interrupt test never separates a correct per-line OR from a wrong field slice or a leak between banks. The bench first walks a table of single-interrupt cases through the boundary codes 0 and 15 and the interrupts at the register edges (0, 7, 24, 31). It then fills both banks with random enable words and random codes, packing the fields by the address rule in R3. Random input patterns are applied on top, and each line is compared with a model built from the bench's own per-interrupt shadow of the codes.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int IRQ_COUNT  = 32;
  localparam int CPU_COUNT  = 2;
  localparam int CODE_W     = 4;
  localparam int LINE_COUNT = (1 << CODE_W) - 1;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 12;
  localparam int BANK_LSB   = 8;
  localparam logic [ADDR_W-1:0] PEND_ADDR = 12'h020;
  localparam int FIELDS_PER_REG = DATA_W / CODE_W;
  localparam int ROUTE_REGS = IRQ_COUNT / FIELDS_PER_REG;
  localparam int CPU_BITS   = (CPU_COUNT > 1) ? $clog2(CPU_COUNT) : 1;
  localparam int REG_BITS   = (ROUTE_REGS > 1) ? $clog2(ROUTE_REGS) : 1;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_MASK  = 2'd1,
    RD_ROUTE = 2'd2,
    RD_PEND  = 2'd3
  } rd_kind_e;

  typedef struct packed {
    logic [CPU_COUNT-1:0]                 maskWr;
    logic [CPU_COUNT-1:0][ROUTE_REGS-1:0] routeWr;
    rd_kind_e                             rdKind;
    logic [CPU_BITS-1:0]                  rdCpu;
    logic [REG_BITS-1:0]                  rdReg;
  } strobe_t;
endpackage

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  logic [ADDR_W-BANK_LSB-1:0] bank;
  logic [BANK_LSB-1:0]        off;
  logic [BANK_LSB-3:0]        slot;
  logic                       aligned;

  always_comb begin
    bank    = busAddr[ADDR_W-1:BANK_LSB];
    off     = busAddr[BANK_LSB-1:0];
    slot    = off[BANK_LSB-1:2];
    aligned = (off[1:0] == 2'b00);
    stb     = '0;
    if (busSel) begin
      if (busAddr == PEND_ADDR) begin
        stb.rdKind = RD_PEND;
      end else if (aligned && (int'(bank) < CPU_COUNT)) begin
        if (slot == '0) begin
          stb.rdKind = RD_MASK;
          stb.rdCpu  = CPU_BITS'(bank);
          if (busWe) stb.maskWr[CPU_BITS'(bank)] = 1'b1;
        end else if (int'(slot) <= ROUTE_REGS) begin
          stb.rdKind = RD_ROUTE;
          stb.rdCpu  = CPU_BITS'(bank);
          stb.rdReg  = REG_BITS'(slot - 1'b1);
          if (busWe) stb.routeWr[CPU_BITS'(bank)][REG_BITS'(slot - 1'b1)] = 1'b1;
        end
      end
    end
  end

  // R11: at most one register is written per access
  p_one_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.maskWr, stb.routeWr}));

  // R10: an access to the status word never writes a register
  p_pend_readonly_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdKind == RD_PEND) |-> (stb.maskWr == '0 && stb.routeWr == '0));
endmodule

// File: rtl/irq_steer_dp.sv
module irq_steer_dp
  import irq_steer_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [IRQ_COUNT-1:0]             irqIn,
  input  logic [DATA_W-1:0]                busWdata,
  input  strobe_t                          stb,
  output logic [DATA_W-1:0]                busRdata,
  output logic [CPU_COUNT*LINE_COUNT-1:0]  cpuLines
);
  logic [IRQ_COUNT-1:0]  maskQ   [CPU_COUNT];
  logic [DATA_W-1:0]     routeQ  [CPU_COUNT][ROUTE_REGS];
  logic [CODE_W-1:0]     codeOf  [CPU_COUNT][IRQ_COUNT];
  logic [IRQ_COUNT-1:0]  liveVec [CPU_COUNT];
  logic [IRQ_COUNT-1:0]  hitVec  [CPU_COUNT][LINE_COUNT];
  logic [LINE_COUNT-1:0] lineD   [CPU_COUNT];
  logic [LINE_COUNT-1:0] lineQ   [CPU_COUNT];

  for (genvar c = 0; c < CPU_COUNT; c++) begin : g_cpu
    // Field slicing: reverse register order, ascending field order inside a register
    for (genvar n = 0; n < IRQ_COUNT; n++) begin : g_irq
      assign codeOf[c][n] =
        routeQ[c][ROUTE_REGS-1-(n/FIELDS_PER_REG)][CODE_W*(n%FIELDS_PER_REG) +: CODE_W];
      assign liveVec[c][n] = (codeOf[c][n] != '0);
      for (genvar k = 0; k < LINE_COUNT; k++) begin : g_line
        assign hitVec[c][k][n] = (codeOf[c][n] == CODE_W'(k + 1));
      end
    end

    for (genvar k = 0; k < LINE_COUNT; k++) begin : g_or
      assign lineD[c][k] = |(irqIn & maskQ[c] & hitVec[c][k]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ[c] <= '0;
        lineQ[c] <= '0;
        for (int j = 0; j < ROUTE_REGS; j++) routeQ[c][j] <= '0;
      end else begin
        if (stb.maskWr[c]) maskQ[c] <= busWdata[IRQ_COUNT-1:0];
        for (int j = 0; j < ROUTE_REGS; j++)
          if (stb.routeWr[c][j]) routeQ[c][j] <= busWdata;
        lineQ[c] <= lineD[c];
      end
    end

    assign cpuLines[c*LINE_COUNT +: LINE_COUNT] = lineQ[c];

    // R2: a write to the enable word is stored at the next edge
    p_mask_load_r2: assert property (@(posedge clk) disable iff (!rstN)
      stb.maskWr[c] |=> (maskQ[c] == $past(busWdata[IRQ_COUNT-1:0])));

    // R6: with nothing both enabled and connected, every line of this CPU drops
    p_blocked_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
      ((irqIn & maskQ[c] & liveVec[c]) == '0) |=> (lineQ[c] == '0));

    // R5: a raised line needs an enabled, asserted input one edge earlier
    p_line_source_r5: assert property (@(posedge clk) disable iff (!rstN)
      (|lineQ[c]) |-> $past(|(irqIn & maskQ[c])));

    for (genvar j = 0; j < ROUTE_REGS; j++) begin : g_hold
      // R3: a routing register changes only through its own write strobe
      p_route_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
        !stb.routeWr[c][j] |=> $stable(routeQ[c][j]));
    end
  end

  always_comb begin
    unique case (stb.rdKind)
      RD_MASK:  busRdata = DATA_W'(maskQ[stb.rdCpu]);
      RD_ROUTE: busRdata = routeQ[stb.rdCpu][stb.rdReg];
      RD_PEND:  busRdata = DATA_W'(irqIn);
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_steer.sv
module irq_steer
  import irq_steer_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [IRQ_COUNT-1:0]            irqIn,
  input  logic                            busSel,
  input  logic                            busWe,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [DATA_W-1:0]               busWdata,
  output logic [DATA_W-1:0]               busRdata,
  output logic [CPU_COUNT*LINE_COUNT-1:0] cpuLines
);
  strobe_t stb;

  irq_steer_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWe   (busWe),
    .busAddr (busAddr),
    .stb     (stb)
  );

  irq_steer_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .busWdata (busWdata),
    .stb      (stb),
    .busRdata (busRdata),
    .cpuLines (cpuLines)
  );
endmodule

// File: tb/irq_steer_test.sv
module irq_steer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [29:0] cpuLines;

  int total = 0;
  int bad = 0;

  logic [3:0]  codeSh [2][32];
  logic [31:0] maskSh [2];

  irq_steer uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .cpuLines(cpuLines)
  );

  always #4 clk = ~clk;

  // Vector fields: {cpu[10], maskOn[9], code[8:5], irq[4:0]}
  localparam logic [10:0] VEC [12] = '{
    {1'b0, 1'b1, 4'd1,  5'd0},
    {1'b0, 1'b1, 4'd15, 5'd31},
    {1'b0, 1'b1, 4'd0,  5'd7},
    {1'b0, 1'b0, 4'd5,  5'd24},
    {1'b0, 1'b1, 4'd8,  5'd7},
    {1'b0, 1'b1, 4'd3,  5'd24},
    {1'b1, 1'b1, 4'd15, 5'd0},
    {1'b1, 1'b1, 4'd1,  5'd31},
    {1'b1, 1'b0, 4'd15, 5'd31},
    {1'b1, 1'b1, 4'd0,  5'd24},
    {1'b1, 1'b1, 4'd9,  5'd16},
    {1'b0, 1'b1, 4'd12, 5'd8}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  function automatic logic [14:0] model(input int c);
    logic [14:0] r = '0;
    for (int n = 0; n < 32; n++)
      if (irqIn[n] && maskSh[c][n] && codeSh[c][n] != 4'd0) r[codeSh[c][n] - 4'd1] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] packReg(input int c, input int j);
    logic [31:0] d = '0;
    for (int f = 0; f < 8; f++) d[4*f +: 4] = codeSh[c][8*(3-j) + f];
    return d;
  endfunction

  task automatic loadBank(input int c);
    busWrite(12'(c*256), maskSh[c]);
    for (int j = 0; j < 4; j++) busWrite(12'(c*256 + 4 + 4*j), packReg(c, j));
  endtask

  task automatic clearShadow();
    for (int c = 0; c < 2; c++) begin
      maskSh[c] = '0;
      for (int n = 0; n < 32; n++) codeSh[c][n] = '0;
    end
  endtask

  // Apply inputs, let the output register capture them, sample away from the edge
  task automatic settle(input logic [31:0] pat);
    @(negedge clk); irqIn = pat;
    @(negedge clk);
  endtask

  task automatic checkLines(input string tag);
    check({tag, " cpu0"}, 32'(cpuLines[14:0]),  32'(model(0)));
    check({tag, " cpu1"}, 32'(cpuLines[29:15]), 32'(model(1)));
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    clearShadow();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 lines", 32'(cpuLines), 32'd0);
    for (int c = 0; c < 2; c++)
      for (int j = 0; j < 5; j++) begin
        busRead(12'(c*256 + 4*j), rd);
        check("R1 reg", rd, 32'd0);
      end

    // R10: raw status and read-only
    irqIn = 32'hA5C3_0F81;
    busRead(12'h020, rd);
    check("R10 pending", rd, 32'hA5C3_0F81);
    busWrite(12'h020, 32'hFFFF_FFFF);
    busRead(12'h000, rd);
    check("R10 write ignored", rd, 32'd0);
    irqIn = '0;

    // R2: enable word readback
    busWrite(12'h100, 32'h8000_0081);
    busRead(12'h100, rd);
    check("R2 mask cpu1", rd, 32'h8000_0081);
    busWrite(12'h100, 32'h0);

    // R3: field positions at the register edges
    busWrite(12'h004, 32'hF000_0000);
    settle(32'h0);
    maskSh[0] = 32'h8000_0000; busWrite(12'h000, maskSh[0]); codeSh[0][31] = 4'd15;
    settle(32'h8000_0000);
    check("R3 irq31 to line14", 32'(cpuLines[14:0]), 32'h4000);
    clearShadow(); loadBank(0);
    busWrite(12'h010, 32'h2000_0003);
    busWrite(12'h000, 32'h0000_0081);
    settle(32'h0000_0001);
    check("R3 irq0 field", 32'(cpuLines[14:0]), 32'h0004);
    settle(32'h0000_0080);
    check("R3 irq7 field", 32'(cpuLines[14:0]), 32'h0002);
    busWrite(12'h004, 32'h0000_0006);
    busWrite(12'h000, 32'h0100_0000);
    settle(32'h0100_0000);
    check("R3 irq24 field", 32'(cpuLines[14:0]), 32'h0020);
    busWrite(12'h004, 32'h0); busWrite(12'h010, 32'h0); busWrite(12'h000, 32'h0);

    // Table walk: R4 code 0, R5 code to line, R6 mask blocks
    for (int v = 0; v < 12; v++) begin
      int c;
      int n;
      clearShadow();
      c = int'(VEC[v][10]);
      n = int'(VEC[v][4:0]);
      codeSh[c][n] = VEC[v][8:5];
      maskSh[c][n] = VEC[v][9];
      loadBank(0); loadBank(1);
      settle(32'h1 << n);
      if (VEC[v][8:5] == 4'd0) checkLines("R4 table");
      else if (!VEC[v][9])     checkLines("R6 table");
      else                     checkLines("R5 table");
    end

    // R7: bank independence
    clearShadow();
    codeSh[0][12] = 4'd4; maskSh[0] = 32'h0000_1000;
    loadBank(0); loadBank(1);
    settle(32'h0000_1000);
    check("R7 cpu1 quiet", 32'(cpuLines[29:15]), 32'd0);
    check("R7 cpu0 line3", 32'(cpuLines[14:0]), 32'h0008);
    busRead(12'h110, rd);
    check("R7 cpu1 route reg", rd, 32'd0);

    // R8: OR of two sources on one line
    clearShadow();
    codeSh[1][3] = 4'd10; codeSh[1][29] = 4'd10; maskSh[1] = 32'h2000_0008;
    loadBank(0); loadBank(1);
    settle(32'h2000_0008);
    check("R8 both", 32'(cpuLines[29:15]), 32'h0200);
    settle(32'h2000_0000);
    check("R8 one left", 32'(cpuLines[29:15]), 32'h0200);
    settle(32'h0);
    check("R8 none", 32'(cpuLines[29:15]), 32'h0);

    // R9: one-edge latency
    @(negedge clk); irqIn = 32'h0000_0008;
    #1 check("R9 before edge", 32'(cpuLines[29:15]), 32'h0);
    @(negedge clk);
    check("R9 after edge", 32'(cpuLines[29:15]), 32'h0200);
    irqIn = '0;

    // R11: unmapped accesses
    busWrite(12'h120, 32'hFFFF_FFFF);
    busWrite(12'h200, 32'hFFFF_FFFF);
    busWrite(12'h002, 32'hFFFF_FFFF);
    busRead(12'h120, rd);  check("R11 read 0x120", rd, 32'd0);
    busRead(12'h200, rd);  check("R11 read 0x200", rd, 32'd0);
    busRead(12'h100, rd);  check("R11 mask intact", rd, 32'h2000_0008);
    busRead(12'h000, rd);  check("R11 mask0 intact", rd, 32'd0);

    // Random banks and inputs, R5/R6/R8 combined
    for (int it = 0; it < 40; it++) begin
      for (int c = 0; c < 2; c++) begin
        maskSh[c] = $urandom;
        for (int n = 0; n < 32; n++) codeSh[c][n] = 4'($urandom);
      end
      loadBank(0); loadBank(1);
      for (int p = 0; p < 4; p++) begin
        settle($urandom & $urandom);
        checkLines("R5 random");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule